// File: doc/BRIEF.md
# PCI Command and Status Error Register

This block holds the combined 32-bit command and status configuration word of a PCI function that can act as both target and bus master. The low half holds the command enables that software writes. The upper half holds status flags that record bus errors and aborts, plus a few fields that always read back a fixed value.

The bus interface sends one-cycle event pulses: parity errors on the address or data phase, PERR_N being driven or sensed, and the three kinds of abort. The block turns these pulses into sticky status flags. Software clears a flag by writing a one to it. The block also issues a one-cycle system error request and a one-cycle fatal error request when the matching enables are set.

Configuration writes use active-high byte enables. A write whose byte-enable pattern cannot be accepted is refused at once with a target-abort request, and the refusal is recorded in the status word. The current register value is always visible on an output, so a read needs no port of its own and accepts any byte-enable pattern.

Top module: `pci_cmdstat_reg`

## Requirements
- R1: After reset, reg_value equals 32'h0200_0000, and serr_req, fatal_req and wr_abort are 0.
- R2: Bits 26:25 always read 2'b01. Bit 21 and the reserved bits 23:22, 20:9, 7 and 5:3 always read 0, even after a write of all ones. The writable command bits are 0, 1, 2, 6 (parity error response) and 8 (system error enable).
- R3: An accepted write updates a command bit only when the byte enable for that bit's byte is set. cfg_be[n] enables bits 8n+7:8n.
- R4: A write is accepted only when cfg_be is 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100 or 4'b1111. Any other pattern, including 4'b0000, drives wr_abort high in the same cycle, changes no bit of the register, and sets bit 27 at the next edge.
- R5: A pulse on ev_addr_perr or ev_data_perr sets bit 31 at the next edge, whatever the value of bit 6.
- R6: Bit 24 is set at the next edge only when ev_perr_seen, ev_is_master and bit 6 are all 1 in the same cycle.
- R7: When bit 8 is 1, an ev_addr_perr pulse gives a one-cycle serr_req pulse in the following cycle and sets bit 30 at that same edge. When bit 8 is 0, neither happens.
- R8: When bit 6 is 1, a parity error on either phase gives a one-cycle fatal_req pulse in the following cycle. When bit 6 is 0, fatal_req stays 0.
- R9: ev_mst_abort sets bit 29, and ev_tgt_abort_rcvd sets bit 28, at the next edge.
- R10: ev_tgt_abort_sent sets bit 27 at the next edge.
- R11: Bits 31:27 and 24 are cleared by an accepted write with cfg_be[3] set and a 1 in the matching data bit. Writing a 0 leaves the bit unchanged. A set event in the same cycle as a clear wins, so the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_addr_perr | input | 1 | Parity error detected on an address phase |
| ev_data_perr | input | 1 | Parity error detected on a data phase |
| ev_perr_seen | input | 1 | PERR_N driven by this function or sensed from another device |
| ev_is_master | input | 1 | This function was bus master for the transfer with the PERR_N event |
| ev_mst_abort | input | 1 | Own master transaction ended by master abort |
| ev_tgt_abort_rcvd | input | 1 | Own master transaction ended by a target abort |
| ev_tgt_abort_sent | input | 1 | This function, as target, ended a transfer with target abort |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Active-high byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| reg_value | output | 32 | Current register value |
| serr_req | output | 1 | Request to assert SERR_N (one-cycle pulse) |
| fatal_req | output | 1 | Fatal bus error request (one-cycle pulse) |
| wr_abort | output | 1 | Target-abort request for a refused write (same cycle) |

## Verification
The assertions assume that each event input is a single-cycle pulse, and that ev_is_master is only meaningful together with ev_perr_seen. They also assume that a write and the events it could race are presented in the same cycle, so the effect of both shows at the next edge. The bench drives every input at the falling edge and holds each pulse for exactly one cycle. It never repeats an event in back-to-back cycles, so each serr_req or fatal_req pulse can be matched to the single cause before it. Same-cycle races between a clear and an event are created on purpose, to check the priority rule.

// File: rtl/pci_cmdstat_reg.sv
module pci_cmdstat_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_addr_perr,
  input  logic        ev_data_perr,
  input  logic        ev_perr_seen,
  input  logic        ev_is_master,
  input  logic        ev_mst_abort,
  input  logic        ev_tgt_abort_rcvd,
  input  logic        ev_tgt_abort_sent,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] reg_value,
  output logic        serr_req,
  output logic        fatal_req,
  output logic        wr_abort
);

  localparam logic [15:0] CMD_WMASK = 16'h0147;
  localparam int PAR_RESP = 6;
  localparam int SERR_EN  = 8;

  logic [15:0] cmd_q;
  logic st_dpe, st_sse, st_rma, st_rta, st_sta, st_dpr;
  logic serr_q, fatal_q;
  logic be_legal, wr_ok;
  logic [7:0] clr;

  always_comb begin
    case (cfg_be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: be_legal = 1'b1;
      default:                   be_legal = 1'b0;
    endcase
  end

  assign wr_abort = cfg_wr & ~be_legal;
  assign wr_ok    = cfg_wr & be_legal;
  assign clr      = (wr_ok && cfg_be[3]) ? cfg_wdata[31:24] : 8'h00;

  wire any_perr = ev_addr_perr | ev_data_perr;
  wire set_sse  = ev_addr_perr & cmd_q[SERR_EN];
  wire set_dpr  = ev_perr_seen & ev_is_master & cmd_q[PAR_RESP];
  wire set_sta  = ev_tgt_abort_sent | wr_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_ok) begin
      if (cfg_be[0]) cmd_q[7:0]  <= cfg_wdata[7:0]  & CMD_WMASK[7:0];
      if (cfg_be[1]) cmd_q[15:8] <= cfg_wdata[15:8] & CMD_WMASK[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_dpe  <= 1'b0;
      st_sse  <= 1'b0;
      st_rma  <= 1'b0;
      st_rta  <= 1'b0;
      st_sta  <= 1'b0;
      st_dpr  <= 1'b0;
      serr_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      st_dpe  <= any_perr          | (st_dpe & ~clr[7]);
      st_sse  <= set_sse           | (st_sse & ~clr[6]);
      st_rma  <= ev_mst_abort      | (st_rma & ~clr[5]);
      st_rta  <= ev_tgt_abort_rcvd | (st_rta & ~clr[4]);
      st_sta  <= set_sta           | (st_sta & ~clr[3]);
      st_dpr  <= set_dpr           | (st_dpr & ~clr[0]);
      serr_q  <= set_sse;
      fatal_q <= any_perr & cmd_q[PAR_RESP];
    end
  end

  assign reg_value = {st_dpe, st_sse, st_rma, st_rta, st_sta, 2'b01, st_dpr,
                      8'h00, cmd_q};
  assign serr_req  = serr_q;
  assign fatal_req = fatal_q;

  // R4
  refused_write_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> (reg_value[15:0] == $past(reg_value[15:0])) && reg_value[27]);

  // R5
  parity_sets_dpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_perr || ev_data_perr) |=> reg_value[31]);

  // R6
  dpr_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_value[24]) |-> $past(ev_perr_seen && ev_is_master && reg_value[PAR_RESP]));

  // R7
  serr_follows_addr_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_perr && reg_value[SERR_EN]) |=> serr_req && reg_value[30]);

  // R7
  serr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> $past(reg_value[SERR_EN] && ev_addr_perr));

  // R8
  fatal_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_req |-> $past(reg_value[PAR_RESP] && (ev_addr_perr || ev_data_perr)));

  // R9
  mst_abort_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mst_abort |=> reg_value[29]);

endmodule

// File: tb/test_pci_cmdstat_reg.sv
module test_pci_cmdstat_reg;
  logic clk = 0;
  logic rst_n = 0;
  logic ev_addr_perr = 0, ev_data_perr = 0, ev_perr_seen = 0, ev_is_master = 0;
  logic ev_mst_abort = 0, ev_tgt_abort_rcvd = 0, ev_tgt_abort_sent = 0;
  logic cfg_wr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] reg_value;
  logic serr_req, fatal_req, wr_abort;
  int total = 0, bad = 0;
  logic abort_seen;

  always #10 clk = ~clk;

  pci_cmdstat_reg i_pci_cmdstat_reg (
    .clk(clk), .rst_n(rst_n),
    .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr),
    .ev_perr_seen(ev_perr_seen), .ev_is_master(ev_is_master),
    .ev_mst_abort(ev_mst_abort), .ev_tgt_abort_rcvd(ev_tgt_abort_rcvd),
    .ev_tgt_abort_sent(ev_tgt_abort_sent),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .reg_value(reg_value), .serr_req(serr_req), .fatal_req(fatal_req),
    .wr_abort(wr_abort));

  // {byte enables, accepted}
  localparam logic [4:0] BE_TABLE [16] = '{
    5'b0000_0, 5'b0001_1, 5'b0010_1, 5'b0011_1,
    5'b0100_1, 5'b0101_0, 5'b0110_0, 5'b0111_0,
    5'b1000_1, 5'b1001_0, 5'b1010_0, 5'b1011_0,
    5'b1100_1, 5'b1101_0, 5'b1110_0, 5'b1111_1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    #1 abort_seen = wr_abort;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  task automatic clear_all;
    wr(4'b1000, 32'hFF00_0000);
    wr(4'b0011, 32'h0000_0000);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", reg_value, 32'h0200_0000);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset value", reg_value, 32'h0200_0000);
    check("R1 outputs idle", {29'd0, serr_req, fatal_req, wr_abort}, 32'd0);

    // byte-enable legality table
    foreach (BE_TABLE[i]) begin
      wr(BE_TABLE[i][4:1], 32'h0000_0000);
      check("R4 abort flag", {31'd0, abort_seen}, {31'd0, ~BE_TABLE[i][0]});
      check("R4 bit27 after write", {31'd0, reg_value[27]}, {31'd0, ~BE_TABLE[i][0]});
      clear_all();
    end

    // R2 fixed/reserved with all-ones write
    wr(4'b1111, 32'h00FF_FFFF);
    check("R2 fixed fields and writable mask", reg_value, 32'h0200_0147);
    // R4 refused write leaves command untouched
    wr(4'b0101, 32'h0000_0000);
    check("R4 refused write no change", reg_value, 32'h0A00_0147);
    clear_all();
    check("R11 clear all", reg_value, 32'h0200_0000);

    // R3 per-byte enables
    wr(4'b0001, 32'h0000_FFFF);
    check("R3 low byte only", reg_value, 32'h0200_0047);
    wr(4'b0010, 32'h0000_0000);
    check("R3 byte1 write keeps byte0", reg_value, 32'h0200_0047);
    wr(4'b0010, 32'h0000_01FF);
    check("R3 byte1 sets bit8", reg_value, 32'h0200_0147);
    clear_all();

    // R5 and R8 with parity response off
    ev_data_perr = 1; idle(); ev_data_perr = 0;
    check("R5 bit31 with bit6 clear", reg_value, 32'h8200_0000);
    check("R8 no fatal when bit6 clear", {31'd0, fatal_req}, 32'd0);
    clear_all();

    // R6 gating
    ev_perr_seen = 1; ev_is_master = 1; idle(); ev_perr_seen = 0; ev_is_master = 0;
    check("R6 no bit24 with bit6 clear", reg_value, 32'h0200_0000);
    wr(4'b0001, 32'h0000_0040);
    ev_perr_seen = 1; ev_is_master = 0; idle(); ev_perr_seen = 0;
    check("R6 no bit24 when not master", reg_value[24], 1'b0);
    ev_perr_seen = 1; ev_is_master = 1; idle(); ev_perr_seen = 0; ev_is_master = 0;
    check("R6 bit24 all three", reg_value[24], 1'b1);

    // R8 fatal pulse
    ev_addr_perr = 1; idle(); ev_addr_perr = 0;
    check("R8 fatal pulse", {31'd0, fatal_req}, 32'd1);
    check("R7 no serr when bit8 clear", {30'd0, serr_req, reg_value[30]}, 32'd0);
    idle();
    check("R8 fatal one cycle", {31'd0, fatal_req}, 32'd0);
    clear_all();

    // R7 serr
    wr(4'b0010, 32'h0000_0100);
    ev_addr_perr = 1; idle(); ev_addr_perr = 0;
    check("R7 serr pulse and bit30", {30'd0, serr_req, reg_value[30]}, 32'd3);
    check("R8 no fatal with bit6 clear", {31'd0, fatal_req}, 32'd0);
    idle();
    check("R7 serr one cycle", {31'd0, serr_req}, 32'd0);
    check("R5 bit31 via address", reg_value[31], 1'b1);
    clear_all();

    // R9 R10
    ev_mst_abort = 1; idle(); ev_mst_abort = 0;
    check("R9 master abort bit29", reg_value, 32'h2200_0000);
    ev_tgt_abort_rcvd = 1; idle(); ev_tgt_abort_rcvd = 0;
    check("R9 target abort rcvd bit28", reg_value, 32'h3200_0000);
    ev_tgt_abort_sent = 1; idle(); ev_tgt_abort_sent = 0;
    check("R10 target abort sent bit27", reg_value, 32'h3A00_0000);

    // R11 W1C
    wr(4'b1000, 32'h0000_0000);
    check("R11 write zero keeps", reg_value, 32'h3A00_0000);
    wr(4'b1000, 32'h2000_0000);
    check("R11 clear bit29 only", reg_value, 32'h1A00_0000);
    ev_tgt_abort_rcvd = 1;
    wr(4'b1000, 32'h1000_0000);
    ev_tgt_abort_rcvd = 0;
    check("R11 event beats clear", reg_value, 32'h1A00_0000);
    wr(4'b1100, 32'hFF00_0000);
    check("R11 clear via halfword", reg_value, 32'h0200_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule